// File: doc/BRIEF.md
# Unaligned Operand Bus-Cycle Splitter

This block sits between a core that issues single operand transfers and a 32-bit memory or I/O bus. The core presents a byte address, an operand size of one, two or four bytes, a direction flag and, for stores, the operand value. The block turns that request into one or two word-aligned bus cycles. Each cycle carries active-low byte enables that mark only the lanes the operand touches. An operand that runs past the end of a 4-byte word needs two cycles. In that case the cycle for the upper word, which holds the operand's most significant bytes, goes out first. The cycle for the lower word follows it.

Operands are little-endian: operand byte k lives at address A+k and travels on lane (A+k) mod 4. For stores, the block moves each byte to its lane. For loads, it collects the returned lanes into a right-justified result and clears the unused upper bytes. A one-cycle completion pulse marks the end of every request. The block takes a new request only while it reports itself idle.

Top module: `bus_split_unit`

## Requirements
- R1: After a synchronous active-high reset the block is idle: `req_ready`=1, `bus_valid`=0, `bus_be_n`=4'b1111, `done`=0.
- R2: `req_len` encodes the size as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. An operand at offset o = A mod 4 with o+size ≤ 4 completes in exactly one cycle. That cycle has `bus_be_n[i]`=0 exactly for lanes o to o+size-1.
- R3: An operand with o+size > 4 takes two cycles. The first goes to word A-o+4 and enables lanes 0 to o+size-5. The second goes to word A-o and enables lanes o to 3. A 4-byte load at address 11 therefore reads three bytes from word 12, then one byte from word 8.
- R4: While `bus_valid`=1, the zero bits of `bus_be_n` form one non-empty contiguous group. While `bus_valid`=0, `bus_be_n` is 4'b1111.
- R5: Bits [1:0] of `bus_addr` are zero in every bus cycle.
- R6: Address, byte enables, write data and direction hold steady from the rise of `bus_valid` until the clock edge where `bus_ready`=1. The next cycle of a split may begin on the following clock.
- R7: For a store, `bus_write`=1 and the enabled lane (A+k) mod 4 of `bus_wdata` carries operand byte k, i.e. `req_wdata[8k+7:8k]`.
- R8: For a load, after completion `rd_data[8k+7:8k]` equals the byte returned on lane (A+k) mod 4 of the cycle addressing that byte's word. Bytes at and above the operand size read as zero.
- R9: `done` is high for exactly one clock, in the clock after the edge where the final cycle saw `bus_ready`. In that same clock `req_ready` is 1 and `rd_data` is valid. `rd_data` stays valid until the next request is accepted.
- R10: A request is accepted only on an edge where `req_ready`=1. A `req_valid` raised while the block is busy causes no bus cycle and leaves the current transfer and its result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe from the core |
| req_addr | input | AW | Byte address of the operand |
| req_len | input | 2 | Operand size code (0:1, 1:2, 2:4 bytes) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store operand, right-justified |
| req_ready | output | 1 | Block idle, request may be presented |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 32 | Right-justified load result |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_addr | output | AW | Word-aligned cycle address |
| bus_be_n | output | 4 | Active-low byte-lane enables |
| bus_write | output | 1 | Cycle direction, 1 = write |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_ready | input | 1 | Bus target completes the current cycle |
| bus_rdata | input | 32 | Read data, sampled when `bus_ready`=1 |

## Verification
The assertions assume that `req_len` never carries the reserved code 3. They also assume that `bus_ready` only matters while `bus_valid` is high, and that the request fields are steady in the cycle a request is accepted. The bench keeps to these assumptions in three ways. It drives only the three legal size codes. Its bus responder raises ready solely during a cycle it has already seen start, and drops ready on the next clock. It changes request fields only at falling edges, before an idle edge. Stray requests during a busy transfer are driven at least one clock before the bus completes, so they fall on edges where the block is busy.

// File: rtl/bus_split_pkg.sv
package bus_split_pkg;

    localparam int LANES     = 4;
    localparam int BYTE_W    = 8;
    localparam int DATA_W    = LANES * BYTE_W;
    localparam int OFF_W     = $clog2(LANES);
    localparam int CNT_W     = OFF_W + 1;
    localparam int SH_W      = OFF_W + $clog2(BYTE_W);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } op_size_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_LAST  = 2'd2
    } phase_e;

    // One bus cycle of a transfer.
    // upper_part: cycle carries the operand's high-order bytes (lane 0 upward)
    // next_word : cycle addresses the word after the base word
    // sh        : byte distance between operand position and lane position
    typedef struct packed {
        logic                 upper_part;
        logic                 next_word;
        logic [OFF_W-1:0]     sh;
        logic [LANES-1:0]     be_n;
    } slot_t;

    function automatic logic [CNT_W-1:0] size_bytes(input logic [1:0] code);
        case (op_size_e'(code))
            SZ_BYTE: size_bytes = CNT_W'(1);
            SZ_HALF: size_bytes = CNT_W'(2);
            default: size_bytes = CNT_W'(LANES);
        endcase
    endfunction

    function automatic logic [LANES-1:0] span_mask(input logic [OFF_W-1:0] first,
                                                   input logic [CNT_W-1:0] count);
        logic [2*LANES-1:0] t;
        t = ((2*LANES)'(1) << count) - (2*LANES)'(1);
        t = t << first;
        span_mask = t[LANES-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] lane_fill(input logic [LANES-1:0] m);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < LANES; i++) begin
            r[i*BYTE_W +: BYTE_W] = {BYTE_W{m[i]}};
        end
        lane_fill = r;
    endfunction

    function automatic logic [DATA_W-1:0] size_fill(input logic [CNT_W-1:0] n);
        size_fill = lane_fill(span_mask('0, n));
    endfunction

    function automatic logic [SH_W-1:0] bit_shift(input logic [OFF_W-1:0] sh);
        bit_shift = {sh, {($clog2(BYTE_W)){1'b0}}};
    endfunction

    function automatic logic [DATA_W-1:0] steer_write(input logic [DATA_W-1:0] data,
                                                      input slot_t s);
        if (s.upper_part) steer_write = data >> bit_shift(s.sh);
        else              steer_write = data << bit_shift(s.sh);
    endfunction

    function automatic logic [DATA_W-1:0] gather_read(input logic [DATA_W-1:0] rdata,
                                                      input slot_t s);
        if (s.upper_part) gather_read = (rdata & lane_fill(~s.be_n)) << bit_shift(s.sh);
        else              gather_read = rdata >> bit_shift(s.sh);
    endfunction

endpackage

// File: rtl/bus_split_plan.sv
module bus_split_plan
    import bus_split_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size_code,
    output slot_t            slot_first,
    output slot_t            slot_last,
    output logic             two_cycles,
    output logic [CNT_W-1:0] nbytes
);
    localparam int END_W = CNT_W + 1;

    logic [END_W-1:0] end_pos;
    logic [END_W-1:0] high_cnt;
    logic [END_W-1:0] low_cnt;
    logic [END_W-1:0] up_shift;

    always_comb begin
        nbytes     = size_bytes(size_code);
        end_pos    = END_W'(offset) + END_W'(nbytes);
        two_cycles = end_pos > END_W'(LANES);
        high_cnt   = end_pos - END_W'(LANES);
        low_cnt    = END_W'(LANES) - END_W'(offset);
        up_shift   = END_W'(LANES) - END_W'(offset);

        slot_last  = '{upper_part: 1'b0, next_word: 1'b0, sh: offset,
                       be_n: ~span_mask(offset, nbytes)};
        slot_first = slot_last;

        if (two_cycles) begin
            slot_first = '{upper_part: 1'b1, next_word: 1'b1,
                           sh: up_shift[OFF_W-1:0],
                           be_n: ~span_mask('0, high_cnt[CNT_W-1:0])};
            slot_last  = '{upper_part: 1'b0, next_word: 1'b0, sh: offset,
                           be_n: ~span_mask(offset, low_cnt[CNT_W-1:0])};
        end
    end
endmodule

// File: rtl/bus_split_merge.sv
module bus_split_merge
    import bus_split_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              capture,
    input  slot_t             slot,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] piece;

    always_comb begin
        piece = gather_read(rdata, slot) & size_fill(nbytes);
    end

    always_ff @(posedge clk) begin
        if (rst)          acc_q <= '0;
        else if (clear)   acc_q <= '0;
        else if (capture) acc_q <= acc_q | piece;
    end

    assign result = acc_q;

    // R8: bytes beyond the operand size are never filled
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        capture |=> (result & ~size_fill($past(nbytes))) == '0);

    // R10 (with R8): a cleared accumulator starts empty
    p_clear_empty_r10: assert property (@(posedge clk) disable iff (rst)
        clear |=> result == '0);
endmodule

// File: rtl/bus_split_seq.sv
module bus_split_seq
    import bus_split_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  slot_t             plan_first,
    input  slot_t             plan_last,
    input  logic              plan_two,
    input  logic [CNT_W-1:0]  plan_bytes,
    input  logic              bus_ready,
    output logic              req_ready,
    output logic              accept,
    output logic              capture,
    output slot_t             cur_slot,
    output logic [CNT_W-1:0]  cur_bytes,
    output logic              done,
    output logic              bus_valid,
    output logic [AW-1:0]     bus_addr,
    output logic [LANES-1:0]  bus_be_n,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata
);
    localparam logic [AW-1:0] WORD_STEP = AW'(LANES);

    phase_e            phase_q, phase_d;
    logic [AW-1:0]     base_q;
    slot_t             first_q, last_q;
    logic              two_q;
    logic              write_q;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  bytes_q;
    logic              done_q;
    logic              handshake;
    logic              final_cycle;

    assign req_ready   = (phase_q == PH_IDLE);
    assign accept      = req_valid && req_ready;
    assign bus_valid   = (phase_q != PH_IDLE);
    assign handshake   = bus_valid && bus_ready;
    assign final_cycle = (phase_q == PH_LAST) || (phase_q == PH_FIRST && !two_q);
    assign capture     = handshake && !write_q;
    assign cur_slot    = (phase_q == PH_LAST) ? last_q : first_q;
    assign cur_bytes   = bytes_q;
    assign done        = done_q;

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:  if (accept)    phase_d = PH_FIRST;
            PH_FIRST: if (handshake) phase_d = two_q ? PH_LAST : PH_IDLE;
            PH_LAST:  if (handshake) phase_d = PH_IDLE;
            default:                 phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            base_q  <= '0;
            first_q <= '{upper_part: 1'b0, next_word: 1'b0, sh: '0, be_n: '1};
            last_q  <= '{upper_part: 1'b0, next_word: 1'b0, sh: '0, be_n: '1};
            two_q   <= 1'b0;
            write_q <= 1'b0;
            data_q  <= '0;
            bytes_q <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= handshake && final_cycle;
            if (accept) begin
                base_q  <= {req_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
                first_q <= plan_first;
                last_q  <= plan_last;
                two_q   <= plan_two;
                write_q <= req_write;
                data_q  <= req_wdata;
                bytes_q <= plan_bytes;
            end
        end
    end

    always_comb begin
        bus_addr  = '0;
        bus_be_n  = '1;
        bus_write = 1'b0;
        bus_wdata = '0;
        if (bus_valid) begin
            bus_addr  = cur_slot.next_word ? base_q + WORD_STEP : base_q;
            bus_be_n  = cur_slot.be_n;
            bus_write = write_q;
            if (write_q) bus_wdata = steer_write(data_q, cur_slot);
        end
    end

    // Assertion helpers: contiguity test on the enabled lanes
    logic [LANES:0] en_m;
    logic [LANES:0] en_low;
    assign en_m   = {1'b0, ~bus_be_n};
    assign en_low = en_m & (~en_m + 1'b1);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!bus_valid && bus_be_n == '1));

    p_lanes_contig_r4: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (en_m != '0 && ((en_m + en_low) & en_m) == '0));

    p_word_align_r5: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> bus_addr[OFF_W-1:0] == '0);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
            $stable(bus_be_n) && $stable(bus_wdata) && $stable(bus_write)));

    p_high_first_r3: assert property (@(posedge clk) disable iff (rst)
        (handshake && phase_q == PH_FIRST && two_q) |=>
            (bus_valid && bus_addr == $past(bus_addr) - WORD_STEP));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && !bus_valid));

    p_done_once_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !handshake) |=> !req_ready);
endmodule

// File: rtl/bus_split_unit.sv
module bus_split_unit
    import bus_split_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_len,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_valid,
    output logic [AW-1:0]     bus_addr,
    output logic [LANES-1:0]  bus_be_n,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata
);
    slot_t            plan_first, plan_last, cur_slot;
    logic             plan_two;
    logic [CNT_W-1:0] plan_bytes, cur_bytes;
    logic             accept, capture;

    bus_split_plan u_plan (
        .offset     (req_addr[OFF_W-1:0]),
        .size_code  (req_len),
        .slot_first (plan_first),
        .slot_last  (plan_last),
        .two_cycles (plan_two),
        .nbytes     (plan_bytes)
    );

    bus_split_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .plan_first (plan_first),
        .plan_last  (plan_last),
        .plan_two   (plan_two),
        .plan_bytes (plan_bytes),
        .bus_ready  (bus_ready),
        .req_ready  (req_ready),
        .accept     (accept),
        .capture    (capture),
        .cur_slot   (cur_slot),
        .cur_bytes  (cur_bytes),
        .done       (done),
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .bus_be_n   (bus_be_n),
        .bus_write  (bus_write),
        .bus_wdata  (bus_wdata)
    );

    bus_split_merge u_merge (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .capture (capture),
        .slot    (cur_slot),
        .nbytes  (cur_bytes),
        .rdata   (bus_rdata),
        .result  (rd_data)
    );

    // R2: a legal size code is presented with every accepted request
    p_size_legal_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> req_len != 2'd3);
endmodule

// File: tb/bus_split_unit_test.sv
module bus_split_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_len;
    logic        req_write;
    logic [31:0] req_wdata;
    logic        req_ready;
    logic        done;
    logic [31:0] rd_data;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic [3:0]  bus_be_n;
    logic        bus_write;
    logic [31:0] bus_wdata;
    logic        bus_ready;
    logic [31:0] bus_rdata;

    always #5 clk = ~clk;

    bus_split_unit uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rd_data(rd_data),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
        .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  be_n;
        logic [31:0] wd;
        logic        wr;
    } cyc_t;

    typedef struct {
        logic        is_read;
        logic [31:0] value;
    } res_t;

    cyc_t exp_q[$];
    res_t res_q[$];
    int   checks = 0;
    int   errors = 0;
    int   lat    = 0;
    int   wait_cnt = 0;
    bit   fresh  = 1'b1;
    bit   prev_done = 1'b0;
    logic [31:0] lock_addr, lock_wd;
    logic [3:0]  lock_be;

    function automatic logic [7:0] mem_at(input logic [31:0] a);
        logic [31:0] t;
        t = a * 32'd13 + 32'd5;
        return t[7:0];
    endfunction

    function automatic bit contiguous(input logic [3:0] en);
        int first = -1, last = -1;
        for (int i = 0; i < 4; i++) if (en[i]) begin
            if (first < 0) first = i;
            last = i;
        end
        if (first < 0) return 1'b0;
        for (int i = first; i <= last; i++) if (!en[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bus responder and cycle scoreboard
    always @(negedge clk) begin
        if (rst) begin
            bus_ready = 1'b0;
            fresh     = 1'b1;
        end else begin
            if (bus_ready) begin
                bus_ready = 1'b0;
                fresh     = 1'b1;
            end
            if (bus_valid) begin
                if (fresh) begin
                    fresh    = 1'b0;
                    wait_cnt = lat;
                    lock_addr = bus_addr;
                    lock_be   = bus_be_n;
                    lock_wd   = bus_wdata;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R10 unexpected bus cycle", bus_addr, 32'h0);
                    end else begin
                        cyc_t e;
                        logic [31:0] m;
                        e = exp_q.pop_front();
                        chk(bus_addr == e.addr, "R3 cycle address/order", bus_addr, e.addr);
                        chk(bus_addr[1:0] == 2'b00, "R5 word alignment", bus_addr, {bus_addr[31:2], 2'b00});
                        chk(bus_be_n == e.be_n, "R2 byte enables", {28'h0, bus_be_n}, {28'h0, e.be_n});
                        chk(contiguous(~bus_be_n), "R4 contiguous enables", {28'h0, bus_be_n}, {28'h0, e.be_n});
                        chk(bus_write == e.wr, "R7 direction", {31'h0, bus_write}, {31'h0, e.wr});
                        if (e.wr) begin
                            m = '0;
                            for (int i = 0; i < 4; i++) if (!e.be_n[i]) m[i*8 +: 8] = 8'hFF;
                            chk((bus_wdata & m) == (e.wd & m), "R7 write lanes", bus_wdata & m, e.wd & m);
                        end
                    end
                end
                if (wait_cnt == 0) begin
                    chk(bus_addr == lock_addr && bus_be_n == lock_be && bus_wdata == lock_wd,
                        "R6 cycle held until ready", bus_addr, lock_addr);
                    for (int i = 0; i < 4; i++) bus_rdata[i*8 +: 8] = mem_at(bus_addr + 32'(i));
                    bus_ready = 1'b1;
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    // Completion monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                chk(!prev_done, "R9 done lasts one clock", 32'h1, 32'h0);
                chk(req_ready && !bus_valid, "R9 idle with done", {31'h0, req_ready}, 32'h1);
                chk(bus_be_n == 4'hF, "R4 enables idle after done", {28'h0, bus_be_n}, 32'hF);
                if (res_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 32'h1, 32'h0);
                end else begin
                    res_t r;
                    r = res_q.pop_front();
                    if (r.is_read) chk(rd_data == r.value, "R8 load result", rd_data, r.value);
                end
            end
            prev_done = done;
        end
    end

    task automatic issue(input logic [31:0] addr, input logic [1:0] code,
                         input logic wr, input logic [31:0] data,
                         input int latency, input bit junk);
        int   n;
        cyc_t lo, hi;
        bit   hi_used;
        res_t r;
        n = (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
        lo = '{addr: {addr[31:2], 2'b00}, be_n: 4'hF, wd: 32'h0, wr: wr};
        hi = '{addr: {addr[31:2], 2'b00} + 32'd4, be_n: 4'hF, wd: 32'h0, wr: wr};
        hi_used = 1'b0;
        r.is_read = !wr;
        r.value   = 32'h0;
        for (int k = 0; k < n; k++) begin
            logic [31:0] a;
            a = addr + 32'(k);
            r.value[k*8 +: 8] = mem_at(a);
            if ({a[31:2], 2'b00} == lo.addr) begin
                lo.be_n[a[1:0]] = 1'b0;
                lo.wd[a[1:0]*8 +: 8] = data[k*8 +: 8];
            end else begin
                hi_used = 1'b1;
                hi.be_n[a[1:0]] = 1'b0;
                hi.wd[a[1:0]*8 +: 8] = data[k*8 +: 8];
            end
        end
        while (!req_ready) @(negedge clk);
        lat = latency;
        if (hi_used) exp_q.push_back(hi);
        exp_q.push_back(lo);
        res_q.push_back(r);
        req_valid = 1'b1;
        req_addr  = addr;
        req_len   = code;
        req_write = wr;
        req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        if (junk) begin
            // R10: stray request while busy
            req_valid = 1'b1;
            req_addr  = addr ^ 32'h0000_0043;
            req_len   = 2'd2;
            req_write = !wr;
            req_wdata = ~data;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R3 all cycles issued", 32'(exp_q.size()), 32'h0);
        if (junk) begin
            repeat (2) begin
                chk(!bus_valid, "R10 stray request ignored", {31'h0, bus_valid}, 32'h0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        rst       = 1'b1;
        req_valid = 1'b0;
        req_addr  = '0;
        req_len   = '0;
        req_write = 1'b0;
        req_wdata = '0;
        bus_ready = 1'b0;
        bus_rdata = '0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", {31'h0, req_ready}, 32'h1);
        chk(bus_valid == 1'b0, "R1 no cycle after reset", {31'h0, bus_valid}, 32'h0);
        chk(bus_be_n == 4'hF, "R1 enables off after reset", {28'h0, bus_be_n}, 32'hF);
        chk(done == 1'b0, "R1 no done after reset", {31'h0, done}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // Boundary case from R3: 4-byte load at address 11
        issue(32'd11, 2'd2, 1'b0, 32'h0, 1, 1'b0);

        for (int off = 0; off < 4; off++)
            for (int code = 0; code < 3; code++)
                for (int wr = 0; wr < 2; wr++)
                    issue(32'h0000_2000 + 32'(off), 2'(code), 1'(wr),
                          32'hA1B2_C3D4 ^ (32'(off) * 32'h0101_0101),
                          (off + code + wr) % 3, 1'b0);

        // R10 with busy-time strays, split and unsplit
        issue(32'h0000_3003, 2'd1, 1'b0, 32'h0, 2, 1'b1);
        issue(32'h0000_3002, 2'd2, 1'b1, 32'h1122_3344, 1, 1'b1);
        issue(32'h0000_3000, 2'd2, 1'b0, 32'h0, 3, 1'b1);
        // wrap across the top of the address space
        issue(32'hFFFF_FFFE, 2'd2, 1'b0, 32'h0, 0, 1'b0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule